// File: doc/BRIEF.md
# Integrator Hold and Digitization Sequencer

This block decides when the integrator outputs of a five-channel charge-measurement module are frozen and converted. Two trigger inputs start a sequence: an external trigger, sent some time ahead of the beam, and a self trigger, raised by the signal itself at beam time. After a delay that depends on which trigger started it, the block raises a hold strobe to the track/hold stages. It waits a short settling time and then steps an external ADC through every stored value. Each channel has three values: fast, slow at unit gain and slow amplified. The block issues one start per value and waits for a conversion-done handshake before it moves on.

Results go into a 16-bit store. Read address = kind × 5 + channel, where kind 0 is fast, kind 1 is slow ×1 and kind 2 is slow ×20. Each stored word has a ready flag. A completed sequence sets the flag and a read of that word clears it, so a reader can tell fresh data from data it has already read. Every delay is counted in ticks from a programmable prescaler, so the same counts serve any system clock.

The sequencer has five states. IDLE waits for a trigger. WAIT_HOLD counts the hold delay. SETTLE keeps the hold strobe up while the track/hold output settles. CONV_REQ issues one ADC start. CONV_WAIT waits for the done handshake and writes the result. The transitions are as follows:
- IDLE→WAIT_HOLD on an accepted trigger.
- WAIT_HOLD→SETTLE when the hold delay expires.
- SETTLE→CONV_REQ when the settle delay expires.
- CONV_REQ→CONV_WAIT unconditionally.
- CONV_WAIT→CONV_REQ on done for any slot except the last.
- CONV_WAIT→IDLE on done for the last slot, which completes the scan.

Top module: `trig_digitize_seq`

## Requirements
- R1: After reset, hold_o and adc_start_o are low, and every read returns rd_ready_o=0 with data 0.
- R2: An accepted external trigger raises hold_o EXT_HOLD_TICKS ticks after its rising edge. The allowed lateness is one tick period plus a few clocks of synchronization.
- R3: An accepted self trigger raises hold_o SELF_HOLD_TICKS ticks after its rising edge, with the same allowed lateness.
- R4: SETTLE_TICKS ticks after hold_o rises, the block issues one-cycle adc_start_o pulses for slots 0 to 14 in ascending order. A slot number is kind × 5 + channel. Each start after the first waits for adc_done_i from the previous one. hold_o stays high until the last done and then drops.
- R5: The adc_data_i value accepted with the done for slot k is returned by a later read at address k.
- R6: A read returns rd_ready_o=1 only if a scan has completed since the previous read of that address. The read clears that address's flag. Results appear one cycle after rd_en_i.
- R7: If a read and a scan completion fall in the same cycle, the read returns the old flag and the flag is left set.
- R8: After an external trigger, self triggers are ignored until that scan completes. A self trigger after completion is accepted.
- R9: A trigger of either kind that arrives while a sequence is in progress neither restarts nor extends the sequence and starts no later sequence.
- R10: Only the rising edge of a trigger counts. A pulse of 3 clocks and a pulse that stays high longer than a whole sequence each start exactly one sequence.
- R11: A tick is issued every tick_div_i+1 clocks, so every delay scales with tick_div_i+1.
- R12: A read at an address of 15 or above returns rd_ready_o=0 and data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_div_i | input | 16 | Prescaler terminal count; one tick every value+1 clocks |
| ext_trig_i | input | 1 | External trigger, asynchronous, edge-detected |
| self_trig_i | input | 1 | Self trigger, asynchronous, edge-detected |
| hold_o | output | 1 | Hold strobe to the track/hold stages |
| adc_start_o | output | 1 | One-cycle conversion request |
| adc_sel_o | output | 4 | Slot being converted (kind × 5 + channel) |
| adc_done_i | input | 1 | Conversion-done pulse |
| adc_data_i | input | 16 | Conversion result, valid with adc_done_i |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 4 | Read address (slot number) |
| rd_data_o | output | 16 | Read data, updated one cycle after rd_en_i |
| rd_ready_o | output | 1 | Fresh-data flag of the word read |

## Verification
The in-line properties assume the following about the inputs:
- tick_div_i changes only while the block is idle.
- Each trigger pulse lasts at least a few clocks, so the synchronizer sees it.
- The ADC returns exactly one done per start.

The stimulus changes the divider only between sequences and keeps trigger pulses at 3 clocks or longer. Its ADC model answers each start once, after a fixed latency. Under these conditions the properties on tick spacing, start pulse width and lockout persistence describe the block and not its environment.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    // Kinds of stored integrator value; slot = kind * channels + channel
    localparam int N_KINDS = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_HOLD,
        ST_SETTLE,
        ST_CONV_REQ,
        ST_CONV_WAIT
    } seq_state_t;

endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic event_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], trig_i};
    end

    assign event_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R10
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !event_o);

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = (cnt_q >= div_i);

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // R11
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import trig_seq_pkg::*;
#(
    parameter int N_SLOT       = 15,
    parameter int SEL_W        = 4,
    parameter int CNT_W        = 11,
    parameter int EXT_TICKS    = 1600,
    parameter int SELF_TICKS   = 1500,
    parameter int SETTLE_TICKS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ext_ev_i,
    input  logic             self_ev_i,
    input  logic             adc_done_i,
    output logic             hold_o,
    output logic             adc_start_o,
    output logic [SEL_W-1:0] adc_sel_o,
    output logic             wr_en_o,
    output logic             scan_done_o
);
    localparam logic [SEL_W-1:0] LAST_SLOT = SEL_W'(N_SLOT - 1);
    localparam logic [CNT_W-1:0] EXT_CNT   = CNT_W'(EXT_TICKS);
    localparam logic [CNT_W-1:0] SELF_CNT  = CNT_W'(SELF_TICKS);
    localparam logic [CNT_W-1:0] SET_CNT   = CNT_W'(SETTLE_TICKS);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [SEL_W-1:0] slot_q, slot_d;
    logic             lock_q, lock_d;
    logic             last_conv;

    assign last_conv = (state_q == ST_CONV_WAIT) && adc_done_i && (slot_q == LAST_SLOT);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        slot_d  = slot_q;
        lock_d  = lock_q;
        if (ext_ev_i) lock_d = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                if (ext_ev_i) begin
                    state_d = ST_WAIT_HOLD;
                    cnt_d   = EXT_CNT;
                end else if (self_ev_i && !lock_q) begin
                    state_d = ST_WAIT_HOLD;
                    cnt_d   = SELF_CNT;
                end
            end
            ST_WAIT_HOLD: begin
                if (tick_i) begin
                    if (cnt_q <= 1) begin
                        state_d = ST_SETTLE;
                        cnt_d   = SET_CNT;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (tick_i) begin
                    if (cnt_q <= 1) begin
                        state_d = ST_CONV_REQ;
                        slot_d  = '0;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            ST_CONV_REQ: begin
                state_d = ST_CONV_WAIT;
            end
            ST_CONV_WAIT: begin
                if (adc_done_i) begin
                    if (slot_q == LAST_SLOT) begin
                        state_d = ST_IDLE;
                        lock_d  = 1'b0;
                    end else begin
                        state_d = ST_CONV_REQ;
                        slot_d  = slot_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            slot_q  <= '0;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            slot_q  <= slot_d;
            lock_q  <= lock_d;
        end
    end

    // Outputs
    always_comb begin
        hold_o      = (state_q == ST_SETTLE) || (state_q == ST_CONV_REQ) || (state_q == ST_CONV_WAIT);
        adc_start_o = (state_q == ST_CONV_REQ);
        adc_sel_o   = slot_q;
        wr_en_o     = (state_q == ST_CONV_WAIT) && adc_done_i;
        scan_done_o = last_conv;
    end

    // R4
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |=> !adc_start_o);

    // R4
    start_slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |-> (adc_sel_o <= LAST_SLOT));

    // R2
    hold_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> ($past(state_q) == ST_WAIT_HOLD && $past(tick_i)));

    // R8
    lock_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !scan_done_o) |=> lock_q);

    // R8
    ext_sets_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_ev_i && !scan_done_o) |=> lock_q);

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_WAIT_HOLD) |=> (state_q != ST_WAIT_HOLD));

endmodule

// File: rtl/result_store.sv
module result_store #(
    parameter int N_SLOT = 15,
    parameter int DW     = 16,
    parameter int AW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          scan_done_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_ready_o
);
    logic [DW-1:0]     mem_q [N_SLOT];
    logic [N_SLOT-1:0] ready_q, ready_d;
    logic              rd_valid;

    assign rd_valid = (32'(rd_addr_i) < N_SLOT);

    // Read clears, completion sets; completion wins
    always_comb begin
        ready_d = ready_q;
        if (rd_en_i && rd_valid) ready_d[rd_addr_i] = 1'b0;
        if (scan_done_i)         ready_d = '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOT; i++) mem_q[i] <= '0;
            ready_q    <= '0;
            rd_data_o  <= '0;
            rd_ready_o <= 1'b0;
        end else begin
            ready_q <= ready_d;
            if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
            if (rd_en_i) begin
                if (rd_valid) begin
                    rd_data_o  <= mem_q[rd_addr_i];
                    rd_ready_o <= ready_q[rd_addr_i];
                end else begin
                    rd_data_o  <= '0;
                    rd_ready_o <= 1'b0;
                end
            end
        end
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done_i |=> (&ready_q));

    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_valid && !scan_done_i) |=> !ready_q[$past(rd_addr_i)]);

    // R12
    bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !rd_valid) |=> (!rd_ready_o && rd_data_o == '0));

endmodule

// File: rtl/trig_digitize_seq.sv
module trig_digitize_seq
    import trig_seq_pkg::*;
#(
    parameter int N_CH            = 5,
    parameter int DATA_W          = 16,
    parameter int DIV_W           = 16,
    parameter int SYNC_STAGES     = 2,
    parameter int EXT_HOLD_TICKS  = 1600,
    parameter int SELF_HOLD_TICKS = 1500,
    parameter int SETTLE_TICKS    = 10,
    localparam int N_SLOT         = N_CH * N_KINDS,
    localparam int ADDR_W         = $clog2(N_SLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  tick_div_i,
    input  logic              ext_trig_i,
    input  logic              self_trig_i,
    output logic              hold_o,
    output logic              adc_start_o,
    output logic [ADDR_W-1:0] adc_sel_o,
    input  logic              adc_done_i,
    input  logic [DATA_W-1:0] adc_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_ready_o
);
    localparam int MAX_A  = (EXT_HOLD_TICKS > SELF_HOLD_TICKS) ? EXT_HOLD_TICKS : SELF_HOLD_TICKS;
    localparam int MAX_T  = (MAX_A > SETTLE_TICKS) ? MAX_A : SETTLE_TICKS;
    localparam int CNT_W  = $clog2(MAX_T + 1);

    logic       tick;
    logic [1:0] trig_raw, trig_ev;
    logic       wr_en, scan_done;

    assign trig_raw = {self_trig_i, ext_trig_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        trig_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .trig_i  (trig_raw[g]),
            .event_o (trig_ev[g])
        );
    end

    tick_prescaler #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (tick_div_i),
        .tick_o (tick)
    );

    seq_ctrl #(
        .N_SLOT       (N_SLOT),
        .SEL_W        (ADDR_W),
        .CNT_W        (CNT_W),
        .EXT_TICKS    (EXT_HOLD_TICKS),
        .SELF_TICKS   (SELF_HOLD_TICKS),
        .SETTLE_TICKS (SETTLE_TICKS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .ext_ev_i    (trig_ev[0]),
        .self_ev_i   (trig_ev[1]),
        .adc_done_i  (adc_done_i),
        .hold_o      (hold_o),
        .adc_start_o (adc_start_o),
        .adc_sel_o   (adc_sel_o),
        .wr_en_o     (wr_en),
        .scan_done_o (scan_done)
    );

    result_store #(.N_SLOT(N_SLOT), .DW(DATA_W), .AW(ADDR_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (adc_sel_o),
        .wr_data_i   (adc_data_i),
        .scan_done_i (scan_done),
        .rd_en_i     (rd_en_i),
        .rd_addr_i   (rd_addr_i),
        .rd_data_o   (rd_data_o),
        .rd_ready_o  (rd_ready_o)
    );

    // R4
    hold_during_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |-> hold_o);

endmodule

// File: tb/trig_digitize_seq_bench.sv
module trig_digitize_seq_bench;
    localparam int NS     = 15;
    localparam int EXT_T  = 1600;
    localparam int SELF_T = 1500;
    localparam int LAT    = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tick_div = '0;
    logic        ext_trig = 1'b0, self_trig = 1'b0;
    logic        hold_o, adc_start_o, adc_done = 1'b0;
    logic [3:0]  adc_sel_o;
    logic [15:0] adc_data = '0;
    logic        main_rd_en = 1'b0, col_rd_en = 1'b0;
    logic [3:0]  main_rd_addr = '0;
    logic        rd_en;
    logic [3:0]  rd_addr;
    logic [15:0] rd_data_o;
    logic        rd_ready_o;

    assign rd_en   = main_rd_en | col_rd_en;
    assign rd_addr = col_rd_en ? 4'd0 : main_rd_addr;

    always #4 clk = ~clk;

    trig_digitize_seq u_trig_digitize_seq (
        .clk(clk), .rst_n(rst_n), .tick_div_i(tick_div),
        .ext_trig_i(ext_trig), .self_trig_i(self_trig),
        .hold_o(hold_o), .adc_start_o(adc_start_o), .adc_sel_o(adc_sel_o),
        .adc_done_i(adc_done), .adc_data_i(adc_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data_o), .rd_ready_o(rd_ready_o)
    );

    int n_tests = 0, n_fail = 0;
    int cyc = 0;
    int exp_sel_q[$];
    logic [7:0] scan_tag = 8'h00;
    bit   collide_rd = 1'b0, col_pending = 1'b0;
    logic col_q = 1'b1;
    int   hold_rises = 0, hold_rise_cyc = 0;
    logic hold_prev = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Hold-rise monitor
    always @(negedge clk) begin
        if (hold_o && !hold_prev) begin
            hold_rises    <= hold_rises + 1;
            hold_rise_cyc <= cyc;
        end
        hold_prev <= hold_o;
    end

    // ADC model and scoreboard monitor for conversion order
    initial begin
        forever begin
            @(negedge clk);
            adc_done = 1'b0;
            if (col_pending) begin
                col_rd_en   = 1'b0;
                col_q       = rd_ready_o;
                col_pending = 1'b0;
            end
            if (adc_start_o) begin
                logic [3:0] s;
                s = adc_sel_o;
                if (exp_sel_q.size() == 0) check(1'b0, "R4 unexpected adc start", int'(s), -1);
                else begin
                    int e;
                    e = exp_sel_q.pop_front();
                    check(int'(s) == e, "R4 conversion order", int'(s), e);
                end
                repeat (LAT - 1) @(negedge clk);
                adc_data = {scan_tag, s, 4'h9};
                adc_done = 1'b1;
                if (collide_rd && s == 4'(NS - 1)) begin
                    col_rd_en   = 1'b1;
                    collide_rd  = 1'b0;
                    col_pending = 1'b1;
                end
            end
        end
    end

    task automatic push_scan();
        for (int i = 0; i < NS; i++) exp_sel_q.push_back(i);
    endtask

    task automatic pulse(input bit is_ext, input int width, output int at);
        @(negedge clk);
        at = cyc;
        if (is_ext) ext_trig = 1'b1; else self_trig = 1'b1;
        repeat (width) @(negedge clk);
        ext_trig  = 1'b0;
        self_trig = 1'b0;
    endtask

    task automatic wait_rise(input int r0);
        while (hold_rises == r0) @(negedge clk);
    endtask

    task automatic wait_fall();
        @(negedge clk);
        while (hold_o) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_delay(input int t0, input int n, input int d, input string req);
        int delta, lo, hi;
        delta = hold_rise_cyc - t0;
        lo = n * (d + 1);
        hi = lo + d + 6;
        check(delta >= lo && delta <= hi, req, delta, lo);
    endtask

    task automatic do_read(input int addr, input bit exp_q, input bit chk_data,
                           input logic [15:0] exp_d, input string req);
        @(negedge clk);
        main_rd_en   = 1'b1;
        main_rd_addr = 4'(addr);
        @(negedge clk);
        main_rd_en = 1'b0;
        check(rd_ready_o == exp_q, req, int'(rd_ready_o), int'(exp_q));
        if (chk_data) check(rd_data_o == exp_d, req, int'(rd_data_o), int'(exp_d));
    endtask

    task automatic read_all(input bit exp_q, input logic [7:0] tag, input string req);
        for (int a = 0; a < NS; a++)
            do_read(a, exp_q, 1'b1, {tag, 4'(a), 4'h9}, req);
    endtask

    // Watchdog
    initial begin
        repeat (120000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int t0, t1, r0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(hold_o == 1'b0, "R1 hold low after reset", int'(hold_o), 0);
        check(adc_start_o == 1'b0, "R1 start low after reset", int'(adc_start_o), 0);
        for (int a = 0; a < NS; a++) do_read(a, 1'b0, 1'b1, 16'h0000, "R1 empty store");
        // R12 out-of-range address
        do_read(15, 1'b0, 1'b1, 16'h0000, "R12 invalid address");

        // R2 + R10: short external pulse
        scan_tag = 8'h11; push_scan(); r0 = hold_rises;
        pulse(1'b1, 3, t0);
        wait_rise(r0);
        check_delay(t0, EXT_T, 0, "R2 external hold delay");
        wait_fall();
        check(exp_sel_q.size() == 0, "R4 all slots converted", exp_sel_q.size(), 0);
        check(hold_rises == r0 + 1, "R10 short pulse one sequence", hold_rises - r0, 1);
        // R5 + R6 data and fresh flags, then cleared
        read_all(1'b1, 8'h11, "R5 R6 fresh data after scan");
        do_read(3, 1'b0, 1'b1, {8'h11, 4'd3, 4'h9}, "R6 second read not fresh");
        do_read(12, 1'b0, 1'b0, 16'h0, "R6 second read not fresh");

        // R3 self trigger
        scan_tag = 8'h22; push_scan(); r0 = hold_rises;
        pulse(1'b0, 4, t0);
        wait_rise(r0);
        check_delay(t0, SELF_T, 0, "R3 self hold delay");
        wait_fall();
        do_read(7, 1'b1, 1'b1, {8'h22, 4'd7, 4'h9}, "R3 R5 self scan data");

        // R8 lockout: self during wait and during scan ignored
        scan_tag = 8'h33; push_scan(); r0 = hold_rises;
        pulse(1'b1, 3, t0);
        repeat (100) @(negedge clk);
        pulse(1'b0, 4, t1);
        wait_rise(r0);
        check_delay(t0, EXT_T, 0, "R8 hold timed from external trigger");
        repeat (20) @(negedge clk);
        pulse(1'b0, 4, t1);
        wait_fall();
        check(hold_rises == r0 + 1, "R8 self triggers locked out", hold_rises - r0, 1);
        // R8 lockout released after completion
        scan_tag = 8'h44; push_scan(); r0 = hold_rises;
        pulse(1'b0, 4, t0);
        wait_rise(r0);
        check_delay(t0, SELF_T, 0, "R8 self accepted after completion");
        wait_fall();

        // R9 external during self sequence ignored
        scan_tag = 8'h55; push_scan(); r0 = hold_rises;
        pulse(1'b0, 4, t0);
        repeat (300) @(negedge clk);
        pulse(1'b1, 3, t1);
        wait_rise(r0);
        check_delay(t0, SELF_T, 0, "R9 busy trigger does not restart");
        wait_fall();
        repeat (1700) @(negedge clk);
        check(hold_rises == r0 + 1, "R9 no later sequence", hold_rises - r0, 1);
        check(exp_sel_q.size() == 0, "R9 single scan", exp_sel_q.size(), 0);
        do_read(14, 1'b1, 1'b1, {8'h55, 4'd14, 4'h9}, "R9 R5 data of scan");

        // R10 long pulse + R7 collision of read and completion
        do_read(0, 1'b1, 1'b0, 16'h0, "R7 clear slot 0 before test");
        scan_tag = 8'h66; push_scan(); r0 = hold_rises;
        collide_rd = 1'b1;
        pulse(1'b1, 2200, t0);
        repeat (1000) @(negedge clk);
        check(hold_rises == r0 + 1, "R10 long pulse one sequence", hold_rises - r0, 1);
        check(col_q == 1'b0, "R7 colliding read returns old flag", int'(col_q), 0);
        do_read(0, 1'b1, 1'b1, {8'h66, 4'd0, 4'h9}, "R7 flag stays set");

        // R11 prescaler scales the delay
        tick_div = 16'd3;
        scan_tag = 8'h77; push_scan(); r0 = hold_rises;
        pulse(1'b0, 4, t0);
        wait_rise(r0);
        check_delay(t0, SELF_T, 3, "R11 delay scaled by divider");
        wait_fall();
        do_read(9, 1'b1, 1'b1, {8'h77, 4'd9, 4'h9}, "R11 R5 data after scaled run");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule